// File: doc/BRIEF.md
# Two-Class Weighted Round-Robin Bus Arbiter

This block decides which of N DMA channels owns a shared bus in the next cycle. Every channel presents a request line and carries two configuration values kept inside the block: a one-bit class (high or low) and a four-bit weight. A high-class requester always wins over every low-class requester. Within a class, a rotating pointer and a credit counter for each channel let the winner hold the bus for as many back-to-back grants as its weight allows. The pointer then moves on to the next index.

The grant leaves the block as a registered one-hot vector with a valid strobe, one cycle after the requests it answers. Configuration is written one channel at a time through a simple write port. The write carries a channel index and a 32-bit word: the class is at bit 15 and the weight field is at bits 14:8. A write whose weight field is larger than 15 is dropped whole. A stored weight of zero counts as one grant per turn. The data path and the bus protocol are outside this block.

Top module: `wrr_qos_arbiter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `grant` is all zeros and `grant_valid` is 0. Reset puts both class pointers at channel 0 and clears every credit.
- R2: In a cycle with no request, the next cycle shows `grant_valid` = 0 and `grant` = 0. Pointers and credits keep their values, so the arbitration that follows continues as if the idle cycle had not occurred.
- R3: When any request is present, the next cycle shows exactly one `grant` bit set, on a channel that requested, and `grant_valid` = 1.
- R4: When requests come from both classes, the grant goes to a high-class channel (class bit 1). A low-class channel (class bit 0) is granted only when no high-class channel requests.
- R5: Within a class, the search starts at the class pointer and runs upward through the indices, wrapping to 0. A channel that wins at a fresh turn is granted on consecutive arbitrations, up to its weight, while it keeps requesting. After the last of those grants the pointer moves to the following index.
- R6: A channel at the pointer that stops requesting gives up the rest of its turn, and its remaining credit is cleared. The next requester found from the pointer wins and starts a fresh turn.
- R7: A stored weight of 0 gives exactly one grant per turn, the same as a weight of 1.
- R8: A write with `cfg_wr_en` = 1 to index `cfg_wr_idx` < N stores bit 15 of `cfg_wr_data` as the class and bits 14:8 as the weight. The new values apply to arbitration from the next cycle, and the weight applies from the channel's next fresh turn.
- R9: A write whose bits 14:8 exceed 15 changes neither the weight nor the class of the addressed channel.
- R10: After reset, the class bits of channels 0 to 5 are 1,1,0,0,0,0 and their weights are 1,13,10,3,4,5.
- R11: A low-class turn cut off by high-class grants keeps its pointer and credit. When the high-class requests stop, that turn resumes with its remaining grants.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_idx | input | $clog2(N) | Channel index of the write |
| cfg_wr_data | input | 32 | Class at bit 15, weight at bits 14:8 |
| req | input | N | One request line per channel |
| grant | output | N | Registered one-hot grant |
| grant_valid | output | 1 | High when `grant` names a channel |

## Verification
Two things can happen in the same cycle: a high-class request can arrive while a low-class channel is partway through its weighted turn. The stimulus table produces this by raising channel 0 during a burst of channel 3. It then checks that channel 0 takes that single grant and that channel 3 afterwards gets only the remaining grants of its weight. A second overlap comes from configuration writes made between bursts. The bench rejects two out-of-range writes and shows through the grant sequence that the weight and class of those channels did not change. It then checks that accepted writes (weight 0, and a class change with weight 2) alter the turn lengths that follow.

// File: rtl/wrr_pkg.sv
// Shared constants and types for the two-class weighted round-robin arbiter.
// Assumes a 32-bit configuration word with the class bit above the weight field.
package wrr_pkg;
    localparam int CFG_DATA_W  = 32;
    localparam int CLS_BIT     = 15;
    localparam int WGT_LSB     = 8;
    localparam int WGT_FLD_W   = 7;
    localparam int WGT_W       = 4;
    localparam int WGT_MAX     = 15;
    localparam logic [WGT_FLD_W-1:0] WGT_LIMIT = WGT_FLD_W'(WGT_MAX);

    typedef enum logic {
        CLS_LO = 1'b0,
        CLS_HI = 1'b1
    } arb_cls_e;
endpackage

// File: rtl/wrr_qos_regs.sv
// Per-channel configuration store (class bit and weight).
// Only writes whose weight field is at most WGT_MAX are accepted, and such a write
// updates both values together. Reset loads the parameter defaults.
// Outputs the effective weight, with a stored 0 raised to 1.
module wrr_qos_regs
    import wrr_pkg::*;
#(
    parameter int              N        = 6,
    parameter int              IDX_W    = $clog2(N),
    parameter logic [N-1:0]    RST_CLS  = '0,
    parameter logic [N*WGT_W-1:0] RST_WGT = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [CFG_DATA_W-1:0] wr_data,
    output logic [N-1:0]          cls_o,
    output logic [WGT_W-1:0]      wgt_eff_o [N]
);
    logic [WGT_FLD_W-1:0] wgt_fld;
    logic                 wr_ok;
    logic [WGT_W-1:0]     wgt_q [N];
    logic [N-1:0]         cls_q;

    // Decode the weight field and judge whether the write is legal.
    assign wgt_fld = wr_data[WGT_LSB +: WGT_FLD_W];
    assign wr_ok   = wr_en && (wgt_fld <= WGT_LIMIT);

    for (genvar i = 0; i < N; i++) begin : g_ch
        logic hit;
        assign hit = wr_ok && (wr_idx == IDX_W'(i));

        // Hold class and weight of channel i; reset to defaults.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cls_q[i] <= RST_CLS[i];
                wgt_q[i] <= RST_WGT[i*WGT_W +: WGT_W];
            end else if (hit) begin
                cls_q[i] <= wr_data[CLS_BIT];
                wgt_q[i] <= wgt_fld[WGT_W-1:0];
            end
        end

        // Raise a zero weight to one grant per turn.
        assign wgt_eff_o[i] = (wgt_q[i] == '0) ? WGT_W'(1) : wgt_q[i];

        // An oversized weight field leaves this channel untouched.
        p_reject_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (wgt_fld > WGT_LIMIT)) |=> ($stable(wgt_q[i]) && $stable(cls_q[i])));
    end

    assign cls_o = cls_q;
endmodule

// File: rtl/wrr_rr_pick.sv
// Combinational round-robin search: returns the first set mask bit at or after
// ptr, wrapping at N. Assumes ptr < N.
module wrr_rr_pick #(
    parameter int N     = 6,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     mask,
    input  logic [IDX_W-1:0] ptr,
    output logic             found,
    output logic [IDX_W-1:0] win
);
    // Scan offsets from far to near so the nearest requester is kept last.
    always_comb begin
        found = 1'b0;
        win   = ptr;
        for (int k = N - 1; k >= 0; k--) begin
            int unsigned t;
            t = int'(ptr) + k;
            if (t >= N) t = t - N;
            if (mask[t]) begin
                found = 1'b1;
                win   = IDX_W'(t);
            end
        end
    end
endmodule

// File: rtl/wrr_class_ctrl.sv
// One priority class: rotating pointer plus a credit counter for each channel.
// A credit counts the grants left in the current turn after the one just given.
// State changes only in cycles where this class issues the grant.
module wrr_class_ctrl
    import wrr_pkg::*;
#(
    parameter int N     = 6,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req_cls,
    input  logic             grant_en,
    input  logic [WGT_W-1:0] wgt_eff [N],
    output logic             found,
    output logic [IDX_W-1:0] win
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    logic [IDX_W-1:0] ptr_q;
    logic [WGT_W-1:0] cred_q [N];
    logic             cont;
    logic [IDX_W-1:0] nxt;

    wrr_rr_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
        .mask  (req_cls),
        .ptr   (ptr_q),
        .found (found),
        .win   (win)
    );

    // Continue the current turn, or find the index after the winner.
    assign cont = found && (win == ptr_q) && (cred_q[win] != '0);
    assign nxt  = (win == LAST) ? '0 : win + 1'b1;

    // Update pointer and credits on each grant issued by this class.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            for (int i = 0; i < N; i++) cred_q[i] <= '0;
        end else if (grant_en && found) begin
            if (cont) begin
                cred_q[win] <= cred_q[win] - 1'b1;
                if (cred_q[win] == WGT_W'(1)) ptr_q <= nxt;
            end else begin
                if (win != ptr_q) cred_q[ptr_q] <= '0;
                cred_q[win] <= wgt_eff[win] - 1'b1;
                ptr_q       <= (wgt_eff[win] == WGT_W'(1)) ? nxt : win;
            end
        end
    end

    // Pointer always names a real channel.
    p_ptr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= LAST);
    // Picker reports a winner exactly when the class has a requester.
    p_found_r3: assert property (@(posedge clk) disable iff (!rst_n)
        found == (req_cls != '0));
    // Without a grant from this class the pointer holds.
    p_ptr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_en && found) |=> $stable(ptr_q));

    for (genvar i = 0; i < N; i++) begin : g_chk
        // Credits hold in cycles without a grant from this class.
        p_cred_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
            !(grant_en && found) |=> $stable(cred_q[i]));
        // A credit never exceeds the largest weight minus one.
        p_cred_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
            cred_q[i] < WGT_W'(WGT_MAX));
    end
endmodule

// File: rtl/wrr_qos_arbiter.sv
// Two-class weighted round-robin arbiter for N requesters.
// The high class preempts the low class; each class rotates with weighted turns.
// The grant is registered and one-hot; the configuration comes from wrr_qos_regs.
module wrr_qos_arbiter
    import wrr_pkg::*;
#(
    parameter int                 N       = 6,
    parameter logic [N-1:0]       RST_CLS = 6'b000011,
    parameter logic [N*WGT_W-1:0] RST_WGT = {4'd5, 4'd4, 4'd3, 4'd10, 4'd13, 4'd1}
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_wr_en,
    input  logic [$clog2(N)-1:0]    cfg_wr_idx,
    input  logic [CFG_DATA_W-1:0]   cfg_wr_data,
    input  logic [N-1:0]            req,
    output logic [N-1:0]            grant,
    output logic                    grant_valid
);
    localparam int IDX_W  = $clog2(N);
    localparam int N_CLS  = 2;

    logic [N-1:0]     cls_w;
    logic [WGT_W-1:0] wgt_eff [N];
    logic [N-1:0]     cls_req   [N_CLS];
    logic             cls_found [N_CLS];
    logic [IDX_W-1:0] cls_win   [N_CLS];
    logic             cls_en    [N_CLS];
    logic [IDX_W-1:0] win_sel;
    logic             any_req;
    logic [N-1:0]     grant_d;
    logic [N-1:0]     grant_q;
    logic             valid_q;

    wrr_qos_regs #(
        .N(N), .IDX_W(IDX_W), .RST_CLS(RST_CLS), .RST_WGT(RST_WGT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr_en),
        .wr_idx    (cfg_wr_idx),
        .wr_data   (cfg_wr_data),
        .cls_o     (cls_w),
        .wgt_eff_o (wgt_eff)
    );

    for (genvar c = 0; c < N_CLS; c++) begin : g_cls
        // Split the requests by class membership.
        if (c == int'(CLS_HI)) begin : g_hi
            assign cls_req[c] = req & cls_w;
            assign cls_en[c]  = 1'b1;
        end else begin : g_lo
            assign cls_req[c] = req & ~cls_w;
            assign cls_en[c]  = !cls_found[int'(CLS_HI)];
        end

        wrr_class_ctrl #(.N(N), .IDX_W(IDX_W)) u_cls (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_cls  (cls_req[c]),
            .grant_en (cls_en[c]),
            .wgt_eff  (wgt_eff),
            .found    (cls_found[c]),
            .win      (cls_win[c])
        );
    end

    // Choose the winning class and form the one-hot grant.
    assign any_req = cls_found[int'(CLS_HI)] || cls_found[int'(CLS_LO)];
    assign win_sel = cls_found[int'(CLS_HI)] ? cls_win[int'(CLS_HI)] : cls_win[int'(CLS_LO)];
    assign grant_d = any_req ? (N'(1) << win_sel) : '0;

    // Register grant and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= '0;
            valid_q <= 1'b0;
        end else begin
            grant_q <= grant_d;
            valid_q <= any_req;
        end
    end

    assign grant       = grant_q;
    assign grant_valid = valid_q;

    // Never more than one grant bit.
    p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // Strobe and grant vector agree.
    p_valid_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid == (grant != '0));
    // Only a previous requester is granted.
    p_grant_requested_r3: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> ((grant & ~$past(req)) == '0));
    // No requests give no grant next cycle.
    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |=> !grant_valid);
    // A high-class request wins over the low class.
    p_hi_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((req & cls_w) != '0) |=> ((grant & $past(cls_w)) != '0));
endmodule

// File: tb/wrr_qos_arbiter_tb.sv
`timescale 1ns/1ps
module wrr_qos_arbiter_tb;
    localparam int N = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_wr_en = 1'b0;
    logic [2:0]   cfg_wr_idx = '0;
    logic [31:0]  cfg_wr_data = '0;
    logic [N-1:0] req = '0;
    logic [N-1:0] grant;
    logic         grant_valid;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #2 clk = ~clk;

    wrr_qos_arbiter u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx), .cfg_wr_data(cfg_wr_data),
        .req(req), .grant(grant), .grant_valid(grant_valid)
    );

    // Rows are {req, expected grant}, run right after the first reset with defaults (R10).
    // R5 rows 0-7, R4/R11 rows 8-10, R2 row 12, R6 row 14, R4 row 16, R6 row 18.
    localparam logic [11:0] VEC [22] = '{
        {6'h18, 6'h08}, {6'h18, 6'h08}, {6'h18, 6'h08},
        {6'h18, 6'h10}, {6'h18, 6'h10}, {6'h18, 6'h10}, {6'h18, 6'h10},
        {6'h18, 6'h08},
        {6'h19, 6'h01}, {6'h18, 6'h08}, {6'h18, 6'h08},
        {6'h10, 6'h10}, {6'h00, 6'h00}, {6'h10, 6'h10},
        {6'h20, 6'h20}, {6'h30, 6'h20},
        {6'h03, 6'h02}, {6'h03, 6'h02}, {6'h01, 6'h01}, {6'h03, 6'h02},
        {6'h24, 6'h20}, {6'h04, 6'h04}
    };

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp,
                         input logic act_v);
        n_tests++;
        if (act !== exp || act_v !== (exp != '0)) begin
            n_fail++;
            $display("FAIL %s: grant=%h valid=%b expected grant=%h valid=%b",
                     tag, act, act_v, exp, (exp != '0));
        end
    endtask

    // Drive requests for one cycle and check the registered grant.
    task automatic step(input string tag, input logic [N-1:0] r, input logic [N-1:0] exp);
        req = r;
        @(posedge clk);
        @(negedge clk);
        check(tag, grant, exp, grant_valid);
    endtask

    // One configuration write with no requests; grant must be idle.
    task automatic cfg_write(input string tag, input logic [2:0] idx, input logic [31:0] d);
        cfg_wr_en   = 1'b1;
        cfg_wr_idx  = idx;
        cfg_wr_data = d;
        req         = '0;
        @(posedge clk);
        @(negedge clk);
        cfg_wr_en = 1'b0;
        check(tag, grant, '0, grant_valid);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req   = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 in reset", grant, '0, grant_valid);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        step("R1 first cycle idle", 6'h00, 6'h00);
        for (int i = 0; i < 22; i++) begin
            step($sformatf("R5/R4/R11/R6/R2/R10 row %0d", i), VEC[i][11:6], VEC[i][5:0]);
        end

        do_reset();
        // R9: oversized weight (16) on ch4 and class 1 with weight 20 on ch2 are dropped.
        cfg_write("R9 write ch4 w16", 3'd4, 32'h0000_1000);
        cfg_write("R9 write ch2 cls1 w20", 3'd2, 32'h0000_9400);
        for (int i = 0; i < 4; i++) step("R9 ch4 weight kept", 6'h30, 6'h10);
        step("R9 ch5 after ch4 turn", 6'h30, 6'h20);
        step("R9 ch0 high", 6'h05, 6'h01);
        step("R9 ch2 still low", 6'h05, 6'h01);
        // R7: weight 0 on ch3 gives one grant per turn.
        cfg_write("R7 write ch3 w0", 3'd3, 32'h0000_0000);
        step("R7 ch3 single grant", 6'h18, 6'h08);
        step("R7 pointer moved to ch4", 6'h18, 6'h10);
        // R8: ch5 becomes high class with weight 2.
        cfg_write("R8 write ch5 cls1 w2", 3'd5, 32'h0000_8200);
        step("R8 ch5 high first", 6'h21, 6'h20);
        step("R8 ch5 second grant", 6'h21, 6'h20);
        step("R8 ch0 after ch5 turn", 6'h21, 6'h01);
        step("R2 idle end", 6'h00, 6'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule